// File: doc/BRIEF.md
# Gate Width Burst Extender

This block turns an asynchronous command gate into a burst of whole pulses taken from a free-running reference pulse stream. The number of pulses in the burst is set only by how long the gate is held high: a gate lasting N pulse periods yields N complete pulses, from one pulse up to about a thousand. No pulse is ever cut short. No pulse is added or lost because of where the gate happened to start within a pulse period.

The block runs on a fast clock at exactly three times the pulse rate and phase-locked to it. The pulse stream is therefore a synchronous level that is high in one fast cycle out of every three. The command gate is first re-timed by a two-flop synchronizer. While the re-timed gate is high and no pulse has yet been let through, a small up/down counter records the number of fast cycles spent waiting. Once the gate falls, the output stays open for that many more cycles while the counter runs back down to zero. The time lost at the start of the burst is therefore made up at the end. The output is the pulse stream ANDed with this open window, registered once.

Top module: `burst_extender`

## Requirements
- R1: While reset is asserted, and afterwards until a gate arrives, `burst_out` is low.
- R2: `gate_in` is re-timed by a two-stage synchronizer on `clk` before it affects anything. A gate level present at a clock edge reaches the control logic two edges later.
- R3: `pulse_in` is high for one `clk` cycle in every three. Each high cycle of `burst_out` copies a high cycle of `pulse_in` from one cycle earlier, so every output pulse is whole.
- R4: A gate held high for 3N clock cycles produces exactly N output pulses, for each of the three possible start phases relative to the pulse stream.
- R5: While the re-timed gate is high and no pulse has passed yet, the early-time counter rises by one on each clock. The window opens in the first cycle in which the re-timed gate and `pulse_in` are high together.
- R6: After the re-timed gate falls, the window stays open for as many cycles as the counter held, one cycle per decrement, and then closes. A 3N-cycle gate therefore gives a window exactly 3N cycles long that starts on a pulse cycle.
- R7: The counter is CNT_W bits wide (CNT_W ≥ 3) and saturates at 2^CNT_W−1 instead of wrapping. With the defaults, a gate of ten or more cycles during which no pulse arrives gives a tail of exactly 7 cycles.
- R8: A gate that is high while a tail is running is ignored until the counter reaches zero. If it is still high at that point, a new burst starts from the idle state.
- R9: Burst length depends only on gate width over the full range of 1 to 1024 pulses. The counter width does not depend on N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, three times the pulse rate, phase-locked to it |
| rst_n | input | 1 | Synchronous active-low reset |
| pulse_in | input | 1 | Reference pulse stream, high one cycle in three |
| gate_in | input | 1 | Asynchronous command gate; its width selects the burst length |
| burst_out | output | 1 | Gated pulse burst, one cycle behind `pulse_in` |

## Verification
The bench builds the block with its defaults, CNT_W = 3 and SYNC_STAGES = 2. The narrow counter means a gate of ten cycles with the pulse stream stalled drives the counter into saturation at 7. The two-stage synchronizer fixes the gate-to-window latency that the bench model tracks cycle by cycle. Start phases are swept over all three pulse offsets. Burst lengths of 1, 2, 5 and 1024 pulses are run. A short gap between gates lets a second gate land inside a running tail.

// File: rtl/burst_pkg.sv
// Shared types for the gate width burst extender.
package burst_pkg;

    // Window controller states.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // no burst; early counter is zero
        ST_WAIT = 2'd1,   // gate high, no pulse passed yet, counting up
        ST_RUN  = 2'd2,   // gate high, window open
        ST_TAIL = 2'd3    // gate low, window held open while counting down
    } win_state_t;

endpackage

// File: rtl/burst_sync.sv
// Multi-stage synchronizer for the asynchronous command gate.
// Assumes STAGES >= 2; output is the input delayed by STAGES clock edges.
module burst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    // Shift the gate level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], async_in};
    end

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/burst_early_ctr.sv
// Saturating up/down counter that measures early gate time.
// Counts up on inc (holding at the maximum) and down on dec (holding at
// zero); inc has priority. Assumes CNT_W >= 3.
module burst_early_ctr #(
    parameter int CNT_W = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic is_zero,
    output logic is_one
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt;

    // Update the count with saturation at both ends.
    always_ff @(posedge clk) begin
        if (!rst_n)                      cnt <= '0;
        else if (inc && cnt != CNT_MAX)  cnt <= cnt + CNT_ONE;
        else if (!inc && dec && cnt != '0) cnt <= cnt - CNT_ONE;
    end

    assign is_zero = (cnt == '0);
    assign is_one  = (cnt == CNT_ONE);

    // R7: a full counter does not wrap when asked to count up.
    a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && cnt == CNT_MAX) |=> (cnt == CNT_MAX));

    // R6: counting down from zero leaves the counter at zero.
    a_r6_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !inc && cnt == '0) |=> (cnt == '0));

    // R5: a count up from below the maximum moves by exactly one.
    a_r5_step_up: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && cnt != CNT_MAX) |=> (cnt == $past(cnt) + CNT_ONE));

endmodule

// File: rtl/burst_window_fsm.sv
// Window controller: decides, per fast cycle, whether the pulse stream may
// pass. Assumes pulse is synchronous to clk and high one cycle in three,
// and that gate_s is already synchronized.
module burst_window_fsm
    import burst_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic gate_s,
    input  logic pulse,
    input  logic cnt_zero,
    input  logic cnt_one,
    output logic cnt_inc,
    output logic cnt_dec,
    output logic open_now
);
    win_state_t st_q, st_d;

    // Next-state and window decision for the current cycle.
    always_comb begin
        st_d     = st_q;
        cnt_inc  = 1'b0;
        cnt_dec  = 1'b0;
        open_now = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (gate_s) begin
                    if (pulse) begin
                        open_now = 1'b1;
                        st_d     = ST_RUN;
                    end else begin
                        cnt_inc = 1'b1;
                        st_d    = ST_WAIT;
                    end
                end
            end
            ST_WAIT, ST_RUN: begin
                if (gate_s) begin
                    if (st_q == ST_RUN || pulse) begin
                        open_now = 1'b1;
                        st_d     = ST_RUN;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end else if (!cnt_zero) begin
                    open_now = 1'b1;
                    cnt_dec  = 1'b1;
                    st_d     = cnt_one ? ST_IDLE : ST_TAIL;
                end else begin
                    st_d = ST_IDLE;
                end
            end
            default: begin
                if (!cnt_zero) begin
                    open_now = 1'b1;
                    cnt_dec  = 1'b1;
                    st_d     = cnt_one ? ST_IDLE : ST_TAIL;
                end else begin
                    st_d = ST_IDLE;
                end
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // R8: a running tail only ends in idle; a new gate cannot re-enter early.
    a_r8_tail_ignores_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_TAIL) |=> (st_q == ST_TAIL || st_q == ST_IDLE));

    // R5: the window opens only on a pulse cycle.
    a_r5_open_on_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q == ST_RUN) |-> $past(pulse));

    // R6: idle is reached only with the early counter drained.
    a_r6_idle_drained: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) |-> cnt_zero);

    // R2: no window opens without a synchronized gate or a pending tail.
    a_r2_no_spurious_open: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && !gate_s) |=> (st_q == ST_IDLE));

endmodule

// File: rtl/burst_extender.sv
// Gate width burst extender top level.
// Synchronizes the command gate, measures the early part of it with an
// up/down counter, and passes whole pulses inside a window whose length
// equals the gate width. Assumes clk is three times the pulse rate and
// phase-locked to pulse_in.
module burst_extender #(
    parameter int CNT_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_in,
    input  logic gate_in,
    output logic burst_out
);
    logic gate_s;
    logic cnt_inc, cnt_dec, cnt_zero, cnt_one;
    logic open_now;

    burst_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (gate_in),
        .sync_out (gate_s)
    );

    burst_early_ctr #(.CNT_W(CNT_W)) i_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (cnt_inc),
        .dec     (cnt_dec),
        .is_zero (cnt_zero),
        .is_one  (cnt_one)
    );

    burst_window_fsm i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .gate_s   (gate_s),
        .pulse    (pulse_in),
        .cnt_zero (cnt_zero),
        .cnt_one  (cnt_one),
        .cnt_inc  (cnt_inc),
        .cnt_dec  (cnt_dec),
        .open_now (open_now)
    );

    // Register the gated pulse so the output is free of combinational edges.
    always_ff @(posedge clk) begin
        if (!rst_n) burst_out <= 1'b0;
        else        burst_out <= pulse_in & open_now;
    end

    // R3: every output pulse is a copy of an input pulse one cycle earlier.
    a_r3_whole_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        burst_out |-> $past(pulse_in));

    // R1: the output stays low in the cycle after a reset edge.
    a_r1_reset_low: assert property (@(posedge clk)
        !rst_n |=> !burst_out);

endmodule

// File: tb/test_burst_extender.sv
module test_burst_extender;
    localparam int CNT_W = 3;
    localparam int MAXC  = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pulse_in = 1'b0;
    logic gate_in = 1'b0;
    logic burst_out;

    int    n_checks = 0;
    int    n_err = 0;
    int    cyc = 0;
    int    pulse_cnt = 0;
    int    ph = 0;
    bit    pulse_en = 1'b1;
    bit    done = 1'b0;
    string cur_req = "R1";

    // Reference model state (behavioural).
    int m_st = 0;       // 0 idle, 1 waiting, 2 open, 3 tail
    int m_cnt = 0;
    bit m_s1 = 1'b0, m_s2 = 1'b0;
    bit m_g, m_o;
    bit exp_out = 1'b0;

    burst_extender #(.CNT_W(CNT_W), .SYNC_STAGES(2)) i_burst_extender (
        .clk       (clk),
        .rst_n     (rst_n),
        .pulse_in  (pulse_in),
        .gate_in   (gate_in),
        .burst_out (burst_out)
    );

    always #4 clk = ~clk;

    // Pulse stream: one high cycle in three, optionally stalled.
    always @(negedge clk) begin
        ph = (ph + 1) % 3;
        pulse_in = pulse_en && (ph == 0);
    end

    // Reference model, stepped on each rising edge.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_s1 = 0; m_s2 = 0; exp_out = 0;
        end else begin
            m_g  = m_s2;
            m_s2 = m_s1;
            m_s1 = gate_in;
            m_o  = 1'b0;
            if (m_st == 0) begin
                if (m_g) begin
                    if (pulse_in) begin m_o = 1; m_st = 2; end
                    else begin m_cnt = 1; m_st = 1; end
                end
            end else if (m_st != 3 && m_g) begin
                if (m_st == 2 || pulse_in) begin m_o = 1; m_st = 2; end
                else if (m_cnt < MAXC) m_cnt = m_cnt + 1;
            end else begin
                if (m_cnt > 0) begin
                    m_o = 1;
                    m_cnt = m_cnt - 1;
                    m_st = (m_cnt == 0) ? 0 : 3;
                end else m_st = 0;
            end
            exp_out = m_o & pulse_in;
        end
    end

    // Per-cycle comparison, away from the rising edge.
    always @(negedge clk) begin
        if (!done) begin
            n_checks++;
            if (burst_out !== exp_out) begin
                n_err++;
                $display("FAIL %s: burst_out=%0b expected %0b at cycle %0d",
                         cur_req, burst_out, exp_out, cyc);
            end
            if (burst_out === 1'b1) pulse_cnt++;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_count(input string req, input int expv);
        n_checks++;
        if (pulse_cnt != expv) begin
            n_err++;
            $display("FAIL %s: pulses=%0d expected %0d", req, pulse_cnt, expv);
        end
    endtask

    // Gate of 3n ticks after an offset; count the pulses that come out.
    task automatic run_burst(input string req, input int n, input int offs);
        cur_req = req;
        wait_cyc(offs);
        pulse_cnt = 0;
        gate_in = 1'b1;
        wait_cyc(3 * n);
        gate_in = 1'b0;
        wait_cyc(14);
        check_count(req, n);
    endtask

    initial begin
        // R1: reset holds the output low.
        wait_cyc(6);
        n_checks++;
        if (burst_out !== 1'b0) begin
            n_err++;
            $display("FAIL R1: burst_out=%0b expected 0 in reset", burst_out);
        end
        rst_n = 1'b1;
        pulse_cnt = 0;
        wait_cyc(12);
        check_count("R1", 0);

        // R2: sync latency tracked by the model on a single burst.
        run_burst("R2", 2, 0);

        // R4/R5/R6: all three start phases for several lengths.
        for (int offs = 0; offs < 3; offs++) begin
            run_burst("R4", 1, offs + 3);
            run_burst("R5", 2, offs + 3);
            run_burst("R6", 5, offs + 3);
        end

        // R3: whole pulses across a longer burst.
        run_burst("R3", 7, 4);

        // R9: top of the range.
        run_burst("R9", 1024, 1);

        // R8: second gate arrives while the tail is running.
        for (int offs = 0; offs < 3; offs++) begin
            cur_req = "R8";
            wait_cyc(offs + 3);
            gate_in = 1'b1;
            wait_cyc(6);
            gate_in = 1'b0;
            wait_cyc(1);
            gate_in = 1'b1;
            wait_cyc(9);
            gate_in = 1'b0;
            wait_cyc(14);
        end

        // R7: pulses stalled under a long gate; counter saturates at 7.
        cur_req = "R7";
        wait_cyc(5);
        pulse_en = 1'b0;
        pulse_cnt = 0;
        gate_in = 1'b1;
        wait_cyc(12);
        gate_in = 1'b0;
        wait_cyc(2);
        pulse_en = 1'b1;
        wait_cyc(14);
        n_checks++;
        if (pulse_cnt < 2 || pulse_cnt > 3) begin
            n_err++;
            $display("FAIL R7: tail pulses=%0d expected 2 or 3", pulse_cnt);
        end

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_err++;
            n_checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

endmodule